// File: doc/BRIEF.md
# Legacy memory attribute decoder

This block steers each host memory access in the first megabyte of the address space to either system DRAM or the PCI bus. Below the display window everything goes to DRAM. The display window from 0xA0000 to 0xBFFFF is governed by a system-management control byte. The area from 0xC0000 to 0xFFFFF is split into thirteen attribute regions. Each region has its own read and write permission bits, and these decide whether that access direction is served by DRAM or passed on to PCI.

Firmware programs the steering through a 32-bit configuration write port. The port is addressed by dword and carries per-byte lane enables. Seven attribute bytes and one management control byte are stored. Any write that lands on one of them triggers a reload of the routing table on the following clock. Decoding of an access is combinational against that table, so a route is available in the same cycle the access is presented.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset all attribute bytes are 0x00 and the management control byte is 0x02, so every access from 0xA0000 to 0xFFFFF, read or write, SMM or not, routes to PCI (`to_dram` = 0).
- R2: Any access with an address below 0xA0000 routes to DRAM (`to_dram` = 1) regardless of configuration, direction or SMM.
- R3: Region 0 covers 0xF0000 to 0xFFFFF. Region k, for k from 1 to 12, covers 16 KB starting at 0xC0000 + (k-1) * 0x4000.
- R4: Attribute byte j sits at configuration offset 0x59 + j. Region 0 uses the high nibble (bits 7:4) of offset 0x59. For j from 1 to 6, the low nibble (bits 3:0) of byte j serves region 2j-1 and the high nibble serves region 2j.
- R5: Within a region's nibble, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A cleared bit sends that direction to PCI. Bits 2 and 3 are ignored.
- R6: A non-SMM access (`acc_smm` = 0) in 0xA0000 to 0xBFFFF routes to DRAM exactly when bit 6 (open) of the control byte at offset 0x72 is set.
- R7: An SMM access (`acc_smm` = 1) in 0xA0000 to 0xBFFFF routes to DRAM when bit 3 (SMM enable) of the control byte is set. Otherwise it follows the open bit as in R6.
- R8: A write on `cfg_dword` d with lane k enabled (`cfg_be[k]` = 1) stores `cfg_wdata[8k+7:8k]` into offset 4d+k. Lanes with a cleared enable, and offsets other than 0x59 to 0x5F and 0x72, leave every route unchanged.
- R9: A configuration write accepted on clock edge N changes routing only from edge N+1 onward. Accesses decoded between edges N and N+1 still use the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_dword | input | 6 | Dword index of the configuration write (offset / 4) |
| cfg_be | input | 4 | Byte lane enables of the write |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| acc_addr | input | 20 | Address of the host access |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| acc_smm | input | 1 | 1 when the access is made in system-management mode |
| to_dram | output | 1 | 1 routes the access to DRAM, 0 routes it to PCI |

## Verification
The assertions assume that every input is driven to a known value on each clock edge once reset is released, and that `acc_addr` never exceeds 20 bits. The hold-time property also assumes that a configuration write is a single-cycle strobe whose effect is judged two edges later. The bench drives all inputs to known values from time zero and changes them only one nanosecond after a falling edge. It pulses `cfg_we` for exactly one edge. It steers the random addresses so that they straddle the display-window boundary and every attribute region edge.

// File: rtl/lmr_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the legacy memory router.
// Assumes: attribute nibbles carry read permission in bit 0, write in bit 1.
package lmr_pkg;

    // Per-region permission pair; set bit means that direction goes to DRAM.
    typedef struct packed {
        logic wr_dram;
        logic rd_dram;
    } attr_t;

    // Extract the permission pair from a 4-bit attribute nibble.
    function automatic attr_t nibble_to_attr(input logic [3:0] nib);
        attr_t a;
        a.wr_dram = nib[1];
        a.rd_dram = nib[0];
        return a;
    endfunction

    // Attribute byte that holds a region's nibble.
    function automatic int unsigned region_byte(input int unsigned region);
        return (region + 1) / 2;
    endfunction

    // Bit offset of a region's nibble inside its byte (even regions high).
    function automatic int unsigned region_shift(input int unsigned region);
        return ((region % 2) == 0) ? 4 : 0;
    endfunction

endpackage

// File: rtl/lmr_cfg_regs.sv
`timescale 1ns/1ps
// Module: lmr_cfg_regs
// Stores the attribute bytes and the management control byte written through
// a dword-addressed port with lane enables. Raises a one-cycle refresh pulse
// on the edge after any write that touched a stored byte.
// Assumes: cfg_we is a single-cycle strobe; other offsets are simply dropped.
module lmr_cfg_regs #(
    parameter int unsigned NUM_ATTR_BYTES = 7,
    parameter int unsigned ATTR_OFF       = 'h59,
    parameter int unsigned SMRAM_OFF      = 'h72,
    parameter int unsigned SMRAM_RST      = 'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [5:0]                  cfg_dword,
    input  logic [3:0]                  cfg_be,
    input  logic [31:0]                 cfg_wdata,
    output logic [NUM_ATTR_BYTES*8-1:0] attr_bytes,
    output logic [7:0]                  smram_byte,
    output logic                        refresh
);

    localparam logic [7:0] SMR_OFF8 = 8'(SMRAM_OFF);
    localparam logic [7:0] SMR_RST8 = 8'(SMRAM_RST);

    logic [NUM_ATTR_BYTES-1:0] attr_hit;
    logic [1:0]                attr_lane [NUM_ATTR_BYTES];
    logic [7:0]                attr_q    [NUM_ATTR_BYTES];
    logic                      smram_hit;

    // Per-byte address match and lane selection for the attribute bytes.
    for (genvar g = 0; g < NUM_ATTR_BYTES; g++) begin : g_attr_dec
        localparam logic [7:0] OFF = 8'(ATTR_OFF + g);
        assign attr_lane[g] = OFF[1:0];
        assign attr_hit[g]  = cfg_we && (cfg_dword == OFF[7:2]) && cfg_be[OFF[1:0]];
        assign attr_bytes[g*8 +: 8] = attr_q[g];
    end

    // Address match for the management control byte.
    assign smram_hit = cfg_we && (cfg_dword == SMR_OFF8[7:2]) && cfg_be[SMR_OFF8[1:0]];

    // Capture written lanes into the attribute bytes.
    always_ff @(posedge clk) begin
        for (int j = 0; j < NUM_ATTR_BYTES; j++) begin
            if (!rst_n) begin
                attr_q[j] <= 8'h00;
            end else if (attr_hit[j]) begin
                attr_q[j] <= cfg_wdata[{attr_lane[j], 3'b000} +: 8];
            end
        end
    end

    // Capture the management control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_byte <= SMR_RST8;
        end else if (smram_hit) begin
            smram_byte <= cfg_wdata[{SMR_OFF8[1:0], 3'b000} +: 8];
        end
    end

    // Request a table reload on the edge after a write to a stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh <= 1'b0;
        end else begin
            refresh <= (|attr_hit) || smram_hit;
        end
    end

endmodule

// File: rtl/lmr_map_table.sv
`timescale 1ns/1ps
// Module: lmr_map_table
// Holds the decoded routing table: one read and one write permission per
// region plus the open and SMM-enable bits. Reloads from the stored bytes
// when refresh is high, so routing changes one edge after the byte write.
// Assumes: NUM_ATTR_BYTES covers the byte of the last region.
module lmr_map_table
    import lmr_pkg::*;
#(
    parameter int unsigned NUM_REGIONS    = 13,
    parameter int unsigned NUM_ATTR_BYTES = 7,
    parameter int unsigned OPEN_BIT       = 6,
    parameter int unsigned GEN_BIT        = 3,
    parameter int unsigned SMRAM_RST      = 'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        refresh,
    input  logic [NUM_ATTR_BYTES*8-1:0] attr_bytes,
    input  logic [7:0]                  smram_byte,
    output logic [NUM_REGIONS-1:0]      map_rd,
    output logic [NUM_REGIONS-1:0]      map_wr,
    output logic                        map_open,
    output logic                        map_gen
);

    localparam logic [7:0] SMR_RST8 = 8'(SMRAM_RST);

    logic [NUM_REGIONS-1:0] nxt_rd;
    logic [NUM_REGIONS-1:0] nxt_wr;

    // Pick each region's nibble out of its attribute byte.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam int unsigned BYTE_IDX = region_byte(g);
        localparam int unsigned SHIFT    = region_shift(g);
        attr_t nib_attr;
        assign nib_attr  = nibble_to_attr(attr_bytes[BYTE_IDX*8 + SHIFT +: 4]);
        assign nxt_rd[g] = nib_attr.rd_dram;
        assign nxt_wr[g] = nib_attr.wr_dram;
    end

    // Bits that no region decodes (upper nibble bits, low nibble of byte 0).
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{attr_bytes, smram_byte};

    // Reload the region permissions when the stored bytes changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_rd <= '0;
            map_wr <= '0;
        end else if (refresh) begin
            map_rd <= nxt_rd;
            map_wr <= nxt_wr;
        end
    end

    // Reload the display-window control bits together with the regions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_open <= SMR_RST8[OPEN_BIT];
            map_gen  <= SMR_RST8[GEN_BIT];
        end else if (refresh) begin
            map_open <= smram_byte[OPEN_BIT];
            map_gen  <= smram_byte[GEN_BIT];
        end
    end

endmodule

// File: rtl/lmr_access_decode.sv
`timescale 1ns/1ps
// Module: lmr_access_decode
// Classifies an access address (base memory, display window, attribute
// region or unmapped) and chooses DRAM or PCI from the routing table.
// Assumes: regions do not overlap each other or the display window.
module lmr_access_decode #(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned NUM_REGIONS = 13,
    parameter int unsigned VGA_BASE    = 'hA0000,
    parameter int unsigned VGA_SIZE    = 'h20000,
    parameter int unsigned BIOS_BASE   = 'hF0000,
    parameter int unsigned BIOS_SIZE   = 'h10000,
    parameter int unsigned EXP_BASE    = 'hC0000,
    parameter int unsigned EXP_SIZE    = 'h4000
) (
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_wr,
    input  logic                   acc_smm,
    input  logic [NUM_REGIONS-1:0] map_rd,
    input  logic [NUM_REGIONS-1:0] map_wr,
    input  logic                   map_open,
    input  logic                   map_gen,
    output logic [NUM_REGIONS-1:0] region_hit,
    output logic                   to_dram
);

    localparam int unsigned XW = ADDR_W + 1;
    localparam logic [XW-1:0] VGA_LO = XW'(VGA_BASE);
    localparam logic [XW-1:0] VGA_HI = XW'(VGA_BASE + VGA_SIZE);

    logic [XW-1:0] addr_x;
    logic          below_vga;
    logic          in_vga;

    assign addr_x = {1'b0, acc_addr};

    // Address window compare for each attribute region.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
        localparam int unsigned LO = (g == 0) ? BIOS_BASE : EXP_BASE + (g - 1) * EXP_SIZE;
        localparam int unsigned SZ = (g == 0) ? BIOS_SIZE : EXP_SIZE;
        localparam logic [XW-1:0] LO_X = XW'(LO);
        localparam logic [XW-1:0] HI_X = XW'(LO + SZ);
        assign region_hit[g] = (addr_x >= LO_X) && (addr_x < HI_X);
    end

    // Base memory and display window classification.
    assign below_vga = addr_x < VGA_LO;
    assign in_vga    = (addr_x >= VGA_LO) && (addr_x < VGA_HI);

    // Route selection by address class.
    always_comb begin
        if (below_vga) begin
            to_dram = 1'b1;
        end else if (in_vga) begin
            to_dram = (acc_smm && map_gen) || map_open;
        end else if (|region_hit) begin
            to_dram = acc_wr ? |(region_hit & map_wr) : |(region_hit & map_rd);
        end else begin
            to_dram = 1'b0;
        end
    end

endmodule

// File: rtl/legacy_mem_router.sv
`timescale 1ns/1ps
// Module: legacy_mem_router (top)
// Routes first-megabyte host accesses to DRAM or PCI from programmable
// attribute bytes and a management control byte written through a
// dword-addressed configuration port.
// Assumes: accesses are decoded in the cycle they are presented; a
// configuration write takes effect from the second edge after it is issued.
module legacy_mem_router #(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned NUM_REGIONS = 13,
    parameter int unsigned ATTR_OFF    = 'h59,
    parameter int unsigned SMRAM_OFF   = 'h72,
    parameter int unsigned SMRAM_RST   = 'h02,
    parameter int unsigned OPEN_BIT    = 6,
    parameter int unsigned GEN_BIT     = 3,
    parameter int unsigned VGA_BASE    = 'hA0000,
    parameter int unsigned VGA_SIZE    = 'h20000,
    parameter int unsigned BIOS_BASE   = 'hF0000,
    parameter int unsigned BIOS_SIZE   = 'h10000,
    parameter int unsigned EXP_BASE    = 'hC0000,
    parameter int unsigned EXP_SIZE    = 'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_dword,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_smm,
    output logic              to_dram
);

    localparam int unsigned NUM_ATTR_BYTES = (NUM_REGIONS + 2) / 2;

    logic [NUM_ATTR_BYTES*8-1:0] attr_bytes;
    logic [7:0]                  smram_byte;
    logic                        refresh;
    logic [NUM_REGIONS-1:0]      map_rd;
    logic [NUM_REGIONS-1:0]      map_wr;
    logic                        map_open;
    logic                        map_gen;
    logic [NUM_REGIONS-1:0]      region_hit;

    lmr_cfg_regs #(
        .NUM_ATTR_BYTES (NUM_ATTR_BYTES),
        .ATTR_OFF       (ATTR_OFF),
        .SMRAM_OFF      (SMRAM_OFF),
        .SMRAM_RST      (SMRAM_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_dword  (cfg_dword),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .attr_bytes (attr_bytes),
        .smram_byte (smram_byte),
        .refresh    (refresh)
    );

    lmr_map_table #(
        .NUM_REGIONS    (NUM_REGIONS),
        .NUM_ATTR_BYTES (NUM_ATTR_BYTES),
        .OPEN_BIT       (OPEN_BIT),
        .GEN_BIT        (GEN_BIT),
        .SMRAM_RST      (SMRAM_RST)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .refresh    (refresh),
        .attr_bytes (attr_bytes),
        .smram_byte (smram_byte),
        .map_rd     (map_rd),
        .map_wr     (map_wr),
        .map_open   (map_open),
        .map_gen    (map_gen)
    );

    lmr_access_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS),
        .VGA_BASE    (VGA_BASE),
        .VGA_SIZE    (VGA_SIZE),
        .BIOS_BASE   (BIOS_BASE),
        .BIOS_SIZE   (BIOS_SIZE),
        .EXP_BASE    (EXP_BASE),
        .EXP_SIZE    (EXP_SIZE)
    ) u_dec (
        .acc_addr   (acc_addr),
        .acc_wr     (acc_wr),
        .acc_smm    (acc_smm),
        .map_rd     (map_rd),
        .map_wr     (map_wr),
        .map_open   (map_open),
        .map_gen    (map_gen),
        .region_hit (region_hit),
        .to_dram    (to_dram)
    );

endmodule

// File: rtl/lmr_route_checker.sv
`timescale 1ns/1ps
// Module: lmr_route_checker
// Property checks relating the decoded route, the routing table and the
// configuration port over time. Attached to the top by the bind below.
// Assumes: inputs are known on every edge after reset release.
module lmr_route_checker #(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned NUM_REGIONS = 13,
    parameter int unsigned VGA_BASE    = 'hA0000,
    parameter int unsigned VGA_SIZE    = 'h20000
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      acc_addr,
    input logic                   acc_wr,
    input logic                   acc_smm,
    input logic                   to_dram,
    input logic [NUM_REGIONS-1:0] region_hit,
    input logic [NUM_REGIONS-1:0] map_rd,
    input logic [NUM_REGIONS-1:0] map_wr,
    input logic                   map_open,
    input logic                   map_gen,
    input logic                   refresh
);

    localparam int unsigned XW = ADDR_W + 1;
    localparam logic [XW-1:0] VGA_LO = XW'(VGA_BASE);
    localparam logic [XW-1:0] VGA_HI = XW'(VGA_BASE + VGA_SIZE);

    logic chk_vga;
    logic chk_low;
    assign chk_low = {1'b0, acc_addr} < VGA_LO;
    assign chk_vga = ({1'b0, acc_addr} >= VGA_LO) && ({1'b0, acc_addr} < VGA_HI);

    AST_BASE_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        chk_low |-> to_dram);  // R2

    AST_SINGLE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_hit));  // R3

    AST_REGION_READ_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && |(region_hit & map_rd)) |-> to_dram);  // R5

    AST_REGION_WRITE_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && |region_hit && !(|(region_hit & map_wr))) |-> !to_dram);  // R5

    AST_WINDOW_CLOSED_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vga && !map_open && !(acc_smm && map_gen)) |-> !to_dram);  // R6

    AST_SMM_WINDOW_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vga && acc_smm && map_gen) |-> to_dram);  // R7

    AST_REFRESH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> $past(cfg_we));  // R8

    AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we, 2) |-> ($stable(map_rd) && $stable(map_wr) && $stable(map_open) && $stable(map_gen)));  // R9

endmodule

bind legacy_mem_router lmr_route_checker #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .VGA_BASE    (VGA_BASE),
    .VGA_SIZE    (VGA_SIZE)
) u_route_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_smm    (acc_smm),
    .to_dram    (to_dram),
    .region_hit (region_hit),
    .map_rd     (map_rd),
    .map_wr     (map_wr),
    .map_open   (map_open),
    .map_gen    (map_gen),
    .refresh    (refresh)
);

// File: tb/tb_legacy_mem_router.sv
`timescale 1ns/1ps
// Bench: behavioural reference (byte array plus one-edge-delayed snapshot)
// compared with the route on every falling edge, plus directed checks.
module tb_legacy_mem_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_dword = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [19:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_smm = 1'b0;
    logic        to_dram;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] cfg_m [256];
    logic [7:0] snap  [256];

    always #4 clk = ~clk;

    legacy_mem_router dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_dword (cfg_dword),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_smm   (acc_smm),
        .to_dram   (to_dram)
    );

    // Reference: bytes written at an edge become visible to routing one edge later.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                cfg_m[i] = 8'h00;
                snap[i]  = 8'h00;
            end
            cfg_m[8'h72] = 8'h02;
            snap[8'h72]  = 8'h02;
        end else begin
            for (int i = 0; i < 256; i++) snap[i] = cfg_m[i];
            if (cfg_we) begin
                for (int k = 0; k < 4; k++) begin
                    if (cfg_be[k]) cfg_m[{cfg_dword, 2'(k)}] = cfg_wdata[8*k +: 8];
                end
            end
        end
    end

    function automatic bit model_route(input int unsigned a, input bit wr, input bit smm);
        int unsigned r;
        logic [7:0] b;
        logic [3:0] nib;
        if (a < 32'hA0000) return 1'b1;
        if (a < 32'hC0000) return (smm && snap[8'h72][3]) || snap[8'h72][6];
        r   = (a >= 32'hF0000) ? 0 : (a - 32'hC0000) / 32'h4000 + 1;
        b   = snap[8'(32'h59 + (r + 1) / 2)];
        nib = (r % 2 == 1) ? b[3:0] : b[7:4];
        return wr ? nib[1] : nib[0];
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: to_dram actual=%0b expected=%0b (addr=%05h wr=%0b smm=%0b)",
                     tag, act, exp, acc_addr, acc_wr, acc_smm);
        end
    endtask

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (acc_addr < 20'hA0000)      chk(to_dram, model_route(acc_addr, acc_wr, acc_smm), "R2 model");
            else if (acc_addr < 20'hC0000) chk(to_dram, model_route(acc_addr, acc_wr, acc_smm),
                                               acc_smm ? "R7 model" : "R6 model");
            else                           chk(to_dram, model_route(acc_addr, acc_wr, acc_smm), "R3 R4 R5 model");
        end
    end

    task automatic set_acc(input logic [19:0] a, input logic wr, input logic smm);
        @(negedge clk); #1;
        acc_addr = a; acc_wr = wr; acc_smm = smm;
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_dword = dw; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic expect_at(input logic [19:0] a, input logic wr, input logic smm,
                             input logic exp, input string tag);
        set_acc(a, wr, smm);
        @(negedge clk);
        chk(to_dram, exp, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state routes the upper area to PCI
        expect_at(20'hF0000, 1'b0, 1'b0, 1'b0, "R1 bios read");
        expect_at(20'hA0000, 1'b0, 1'b1, 1'b0, "R1 smm window");
        expect_at(20'hC8000, 1'b1, 1'b0, 1'b0, "R1 region write");
        // R2: base memory always DRAM
        expect_at(20'h00400, 1'b0, 1'b0, 1'b1, "R2 low read");
        expect_at(20'h9FFFF, 1'b1, 1'b1, 1'b1, "R2 top edge");

        // R9: offset 0x59 high nibble = 3, seen one edge after the write edge
        set_acc(20'hF0000, 1'b0, 1'b0);
        cfg_write(6'h16, 4'b0010, 32'h0000_3100);
        @(negedge clk); chk(to_dram, 1'b0, "R9 old setting");
        @(negedge clk); chk(to_dram, 1'b1, "R9 new setting");
        expect_at(20'hF0000, 1'b1, 1'b0, 1'b1, "R5 bios write");
        expect_at(20'hFFFFF, 1'b0, 1'b0, 1'b1, "R3 bios top");

        // R4: offset 0x5A = 0x21 -> region 1 read, region 2 write
        cfg_write(6'h16, 4'b0100, 32'h0021_0000);
        expect_at(20'hC0000, 1'b0, 1'b0, 1'b1, "R4 region1 low nibble");
        expect_at(20'hC0000, 1'b1, 1'b0, 1'b0, "R5 region1 write blocked");
        expect_at(20'hC3FFF, 1'b0, 1'b0, 1'b1, "R3 region1 end");
        expect_at(20'hC4000, 1'b1, 1'b0, 1'b1, "R4 region2 high nibble");
        expect_at(20'hC4000, 1'b0, 1'b0, 1'b0, "R5 region2 read blocked");

        // R8: disabled lanes and foreign offsets change nothing
        cfg_write(6'h16, 4'b0000, 32'hFFFF_FFFF);
        expect_at(20'hC0000, 1'b1, 1'b0, 1'b0, "R8 lanes disabled");
        cfg_write(6'h18, 4'b1111, 32'hFFFF_FFFF);
        expect_at(20'hC4000, 1'b0, 1'b0, 1'b0, "R8 foreign offset");
        // R8: four lanes at once, 0x5C..0x5F
        cfg_write(6'h17, 4'b1111, 32'h3322_1100);
        expect_at(20'hEC000, 1'b1, 1'b0, 1'b1, "R8 lane3 region12");
        expect_at(20'hE8000, 1'b0, 1'b0, 1'b1, "R8 lane3 region11");
        expect_at(20'hD8000, 1'b1, 1'b0, 1'b0, "R8 lane1 region7");

        // R3: both edges of every region, both directions (model-checked)
        for (int r = 0; r < 13; r++) begin
            int unsigned lo;
            int unsigned sz;
            lo = (r == 0) ? 32'hF0000 : 32'hC0000 + (r - 1) * 32'h4000;
            sz = (r == 0) ? 32'h10000 : 32'h4000;
            for (int w = 0; w < 2; w++) begin
                set_acc(20'(lo), w[0], 1'b0);
                set_acc(20'(lo + sz - 1), w[0], 1'b0);
            end
        end

        // R6 and R7: display window control
        cfg_write(6'h1C, 4'b0100, 32'h0040_0000);
        expect_at(20'hA0000, 1'b0, 1'b0, 1'b1, "R6 open non-smm");
        expect_at(20'hBFFFF, 1'b1, 1'b1, 1'b1, "R7 open smm");
        cfg_write(6'h1C, 4'b0100, 32'h0008_0000);
        expect_at(20'hB0000, 1'b0, 1'b0, 1'b0, "R6 closed non-smm");
        expect_at(20'hB0000, 1'b0, 1'b1, 1'b1, "R7 smm enable");
        expect_at(20'hC0000, 1'b0, 1'b1, 1'b1, "R7 smm outside window");
        cfg_write(6'h1C, 4'b0100, 32'h0000_0000);
        expect_at(20'hA0000, 1'b1, 1'b1, 1'b0, "R7 smm disabled");

        // Mixed traffic with occasional configuration writes (model-checked)
        for (int n = 0; n < 3000; n++) begin
            if (n % 16 == 0) begin
                logic [5:0] dw;
                case ($urandom_range(0, 3))
                    0: dw = 6'h16;
                    1: dw = 6'h17;
                    2: dw = 6'h1C;
                    default: dw = 6'h18;
                endcase
                cfg_write(dw, 4'($urandom), $urandom);
            end
            set_acc(20'($urandom_range(32'h9F000, 32'hFFFFF)), 1'($urandom), 1'($urandom));
        end

        @(negedge clk);
        finish_run();
    end

endmodule